// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the general-register store of a small 32-bit RISC core. The datapath sees sixteen architectural registers, numbered 0 to 15. Behind them sit 25 physical registers. A 2-bit processor-mode input decides which physical copy a given register number reaches. The three privileged modes get private copies of some high registers, so an exception handler can use them without saving the interrupted program's values first.

Register 15 is the program counter. It holds a word-aligned 26-bit byte address, so only address bits 25:2 are kept. The other bits always read as zero, and any value written to them is dropped. The block has two combinational read ports and one write port. The write port has an enable and takes effect on the rising clock edge. A synchronous active-high reset zeroes the program counter. When a parameter selects it, reset also clears every other register.

Top module: `mode_banked_regfile`

## Requirements
- R1: Registers 0 to 9 reach the same physical register in every mode. A value written to one of them in any mode reads back in all four modes.
- R2: The mode input is encoded as 00 user, 01 fast interrupt, 10 interrupt, 11 supervisor. In fast-interrupt mode, registers 10 to 14 reach five private copies. Writing those copies leaves the user and other mode values untouched.
- R3: In interrupt mode and in supervisor mode, only registers 13 and 14 are private, with one separate pair per mode. Registers 10 to 12 in these modes reach the user copies.
- R4: In user mode every register number reaches its base copy. Taken over all modes there are exactly 25 independent physical registers.
- R5: Reading register 15 returns zero in bits 31:26 and in bits 1:0.
- R6: A write to register 15 stores data bits 25:2 only. It is shared by all modes.
- R7: A write takes effect at the rising clock edge only while the write enable is high. With the enable low, no register changes.
- R8: A read of the register that is being written in the same cycle returns the value held before the edge.
- R9: Synchronous reset clears the program counter to zero. With CLEAR_ALL set, it clears all other registers as well.
- R10: The two read ports are independent. Each one returns the register its own address selects, in the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Processor mode (00 user, 01 fast interrupt, 10 interrupt, 11 supervisor) |
| rd_a_addr | input | 4 | Register number for read port A |
| rd_a_data | output | 32 | Read port A data, combinational |
| rd_b_addr | input | 4 | Register number for read port B |
| rd_b_data | output | 32 | Read port B data, combinational |
| we | input | 1 | Write enable |
| wr_addr | input | 4 | Register number for the write port |
| wr_data | input | 32 | Write data |

## Verification
Assertions check several properties on every cycle. They check the index mapping for each port: low registers are shared, user mode maps directly, and only the correct ranges are privately banked. They check that the unstored bits of the program counter read as zero. They also check that the state holds when the write enable is low, and that a program-counter write keeps exactly bits 25:2.

Some properties only the bench's sweeps can show: that the 25 copies are really independent, that a value written in one mode is seen or not seen in each of the others, and that a read in the same cycle as a write returns the old value. The bench writes a distinct pattern to every register in every mode. It then reads the whole architectural view back through both ports in all four modes and compares it against a model that tracks the physical copies.

// File: rtl/rf_bank_pkg.sv
package rf_bank_pkg;

    typedef enum logic [1:0] {
        MODE_USER = 2'b00,
        MODE_FAST = 2'b01,
        MODE_IRQ  = 2'b10,
        MODE_SVC  = 2'b11
    } cpu_mode_e;

    localparam int ARCH_REGS   = 16;
    localparam int ARCH_IDX_W  = $clog2(ARCH_REGS);
    localparam int PC_ARCH     = ARCH_REGS - 1;
    localparam int FAST_FIRST  = 10;
    localparam int FAST_LAST   = 14;
    localparam int FAST_COUNT  = FAST_LAST - FAST_FIRST + 1;
    localparam int PRIV_FIRST  = 13;
    localparam int PRIV_COUNT  = FAST_LAST - PRIV_FIRST + 1;
    localparam int FAST_BASE   = ARCH_REGS;
    localparam int IRQ_BASE    = FAST_BASE + FAST_COUNT;
    localparam int SVC_BASE    = IRQ_BASE + PRIV_COUNT;
    localparam int PHYS_REGS   = SVC_BASE + PRIV_COUNT;
    localparam int PHYS_IDX_W  = $clog2(PHYS_REGS);

endpackage

// File: rtl/rf_bank_map.sv
module rf_bank_map
    import rf_bank_pkg::*;
(
    input  cpu_mode_e               mode,
    input  logic [ARCH_IDX_W-1:0]   arch,
    output logic [PHYS_IDX_W-1:0]   phys
);

    logic in_fast_range;
    logic in_priv_range;
    logic [PHYS_IDX_W-1:0] fast_off;
    logic [PHYS_IDX_W-1:0] priv_off;
    logic [PHYS_IDX_W-1:0] base_idx;

    always_comb begin
        base_idx      = PHYS_IDX_W'(arch);
        in_fast_range = (int'(arch) >= FAST_FIRST) && (int'(arch) <= FAST_LAST);
        in_priv_range = (int'(arch) >= PRIV_FIRST) && (int'(arch) <= FAST_LAST);
        fast_off      = base_idx - PHYS_IDX_W'(FAST_FIRST);
        priv_off      = base_idx - PHYS_IDX_W'(PRIV_FIRST);
        phys          = base_idx;
        unique case (mode)
            MODE_FAST: if (in_fast_range) phys = PHYS_IDX_W'(FAST_BASE) + fast_off;
            MODE_IRQ:  if (in_priv_range) phys = PHYS_IDX_W'(IRQ_BASE) + priv_off;
            MODE_SVC:  if (in_priv_range) phys = PHYS_IDX_W'(SVC_BASE) + priv_off;
            default:   phys = base_idx;
        endcase
    end

endmodule

// File: rtl/rf_bank_store.sv
module rf_bank_store
    import rf_bank_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 26,
    parameter bit CLEAR_ALL = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [PHYS_IDX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [PHYS_IDX_W-1:0] rd0_idx,
    output logic [DATA_W-1:0]     rd0_data,
    input  logic [PHYS_IDX_W-1:0] rd1_idx,
    output logic [DATA_W-1:0]     rd1_data
);

    localparam int PC_W    = ADDR_W - 2;
    localparam int PC_PHYS = PC_ARCH;

    typedef struct packed {
        logic [PHYS_REGS-1:0][DATA_W-1:0] gpr;
        logic [PC_W-1:0]                  pc;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.pc = '0;
            if (CLEAR_ALL) st_d.gpr = '0;
        end else if (we) begin
            if (wr_idx == PHYS_IDX_W'(PC_PHYS)) st_d.pc = wr_data[PC_W+1:2];
            else                                st_d.gpr[wr_idx] = wr_data;
        end
        st_d.gpr[PC_PHYS] = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    function automatic logic [DATA_W-1:0] fetch(input logic [PHYS_IDX_W-1:0] idx,
                                                input store_t s);
        if (idx == PHYS_IDX_W'(PC_PHYS)) return DATA_W'({s.pc, 2'b00});
        return s.gpr[idx];
    endfunction

    assign rd0_data = fetch(rd0_idx, st_q);
    assign rd1_data = fetch(rd1_idx, st_q);

    assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !we |=> (st_q == $past(st_q)));

    assert_pc_keeps_addr_bits_R6: assert property (@(posedge clk) disable iff (rst)
        (we && wr_idx == PHYS_IDX_W'(PC_PHYS)) |=> (st_q.pc == $past(wr_data[PC_W+1:2])));

endmodule

// File: rtl/mode_banked_regfile.sv
module mode_banked_regfile
    import rf_bank_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 26,
    parameter bit CLEAR_ALL = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  mode,
    input  logic [3:0]  rd_a_addr,
    output logic [31:0] rd_a_data,
    input  logic [3:0]  rd_b_addr,
    output logic [31:0] rd_b_data,
    input  logic        we,
    input  logic [3:0]  wr_addr,
    input  logic [31:0] wr_data
);

    localparam int NUM_PORTS = 3;

    cpu_mode_e             mode_e;
    logic [ARCH_IDX_W-1:0] arch_sel [NUM_PORTS];
    logic [PHYS_IDX_W-1:0] phys_sel [NUM_PORTS];

    assign mode_e      = cpu_mode_e'(mode);
    assign arch_sel[0] = rd_a_addr;
    assign arch_sel[1] = rd_b_addr;
    assign arch_sel[2] = wr_addr;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_map
        rf_bank_map u_map (
            .mode (mode_e),
            .arch (arch_sel[p]),
            .phys (phys_sel[p])
        );

        assert_low_shared_R1: assert property (@(posedge clk) disable iff (rst)
            (int'(arch_sel[p]) < FAST_FIRST) |-> (int'(phys_sel[p]) == int'(arch_sel[p])));

        assert_fast_bank_R2: assert property (@(posedge clk) disable iff (rst)
            (mode_e == MODE_FAST && int'(arch_sel[p]) >= FAST_FIRST && int'(arch_sel[p]) <= FAST_LAST)
            |-> (int'(phys_sel[p]) >= FAST_BASE && int'(phys_sel[p]) < IRQ_BASE));

        assert_priv_bank_R3: assert property (@(posedge clk) disable iff (rst)
            ((mode_e == MODE_IRQ || mode_e == MODE_SVC) && int'(arch_sel[p]) < PRIV_FIRST)
            |-> (int'(phys_sel[p]) == int'(arch_sel[p])));

        assert_user_direct_R4: assert property (@(posedge clk) disable iff (rst)
            (mode_e == MODE_USER) |-> (int'(phys_sel[p]) == int'(arch_sel[p])));

        assert_index_bound_R4: assert property (@(posedge clk) disable iff (rst)
            int'(phys_sel[p]) < PHYS_REGS);
    end

    rf_bank_store #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .CLEAR_ALL (CLEAR_ALL)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .we       (we),
        .wr_idx   (phys_sel[2]),
        .wr_data  (wr_data),
        .rd0_idx  (phys_sel[0]),
        .rd0_data (rd_a_data),
        .rd1_idx  (phys_sel[1]),
        .rd1_data (rd_b_data)
    );

    assert_pc_unused_bits_R5: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_a_addr) == PC_ARCH) |-> (rd_a_data[31:26] == 6'd0 && rd_a_data[1:0] == 2'd0));

endmodule

// File: tb/mode_banked_regfile_bench.sv
module mode_banked_regfile_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  mode;
    logic [3:0]  rd_a_addr, rd_b_addr, wr_addr;
    logic [31:0] rd_a_data, rd_b_data, wr_data;
    logic        we;

    int compared = 0;
    int mismatched = 0;
    logic [31:0] model [25];

    always #5 clk = ~clk;

    mode_banked_regfile #(.CLEAR_ALL(1'b1)) u_mode_banked_regfile (
        .clk, .rst, .mode, .rd_a_addr, .rd_a_data, .rd_b_addr, .rd_b_data,
        .we, .wr_addr, .wr_data
    );

    function automatic int slot(input int m, input int a);
        if (a < 10 || a == 15) return a;
        if (m == 1) return 16 + a - 10;
        if (a < 13 || m == 0) return a;
        return (m == 2 ? 21 : 23) + a - 13;
    endfunction

    function automatic logic [31:0] expect_val(input int m, input int a);
        if (a == 15) return model[15] & 32'h03FF_FFFC;
        return model[slot(m, a)];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input int m, input int a, input logic [31:0] d, input logic en);
        @(negedge clk);
        mode = 2'(m); wr_addr = 4'(a); wr_data = d; we = en;
        @(negedge clk);
        we = 1'b0;
        if (en) model[slot(m, a)] = d;
    endtask

    task automatic read_all(input string req);
        for (int m = 0; m < 4; m++) begin
            for (int a = 0; a < 16; a++) begin
                mode = 2'(m); rd_a_addr = 4'(a); rd_b_addr = 4'(15 - a);
                #1;
                check(req, rd_a_data, expect_val(m, a));
                check({req, " R10"}, rd_b_data, expect_val(m, 15 - a));
            end
        end
    endtask

    initial begin
        #1_000_000;
        mismatched++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        rst = 1'b1; we = 1'b0; mode = 2'd0; rd_a_addr = '0; rd_b_addr = '0;
        wr_addr = '0; wr_data = '0;
        for (int i = 0; i < 25; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        read_all("R9 reset");

        // R1 R2 R3 R4: distinct pattern per register per mode, full readback
        for (int m = 0; m < 4; m++) begin
            for (int a = 0; a < 15; a++) begin
                wr(m, a, 32'h5A00_0000 ^ (m << 20) ^ (a << 8) ^ (32'h0101_0101 * (a + 1)), 1'b1);
                read_all("R1 R2 R3 R4 sweep");
            end
        end

        // R5 R6: PC masking
        wr(2, 15, 32'hFFFF_FFFF, 1'b1);
        read_all("R5 R6 pc all ones");
        mode = 2'd0; rd_a_addr = 4'd15; #1;
        check("R6 pc value", rd_a_data, 32'h03FF_FFFC);
        wr(3, 15, 32'hFC00_0007, 1'b1);
        rd_a_addr = 4'd15; #1;
        check("R5 pc dropped bits", rd_a_data, 32'h0000_0004);

        // R7: enable low changes nothing
        for (int m = 0; m < 4; m++) begin
            wr(m, 11, 32'hDEAD_BEEF, 1'b0);
            wr(m, 15, 32'h0123_4568, 1'b0);
        end
        read_all("R7 enable low");

        // R8: read during write returns old value
        @(negedge clk);
        mode = 2'd1; wr_addr = 4'd12; wr_data = 32'hCAFE_F00D; we = 1'b1;
        rd_a_addr = 4'd12; rd_b_addr = 4'd12;
        #1;
        check("R8 old value A", rd_a_data, model[slot(1, 12)]);
        check("R8 old value B", rd_b_data, model[slot(1, 12)]);
        @(negedge clk);
        we = 1'b0;
        model[slot(1, 12)] = 32'hCAFE_F00D;
        #1;
        check("R8 new value after edge", rd_a_data, 32'hCAFE_F00D);
        read_all("R8 isolation");

        // R9: reset mid-run clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 25; i++) model[i] = '0;
        read_all("R9 mid reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule